// File: doc/BRIEF.md
# Windowed Video Region Color Averager

This block sits on a parallel video pixel stream (a pixel-valid qualifier, a 24-bit RGB word, an end-of-row marker and an end-of-frame marker) and measures the mean color of several square screen regions at once. It tracks the column and row of every incoming pixel from the two markers. It does not need any frame geometry to be programmed.

Every region has its own accumulator set, with one running sum per color channel. On every valid pixel, each region tests the current coordinate against its own window and adds the pixel if the coordinate is inside. All regions test the same pixel together, so regions may overlap or lie anywhere on the raster. A region's side is a power of two. Its mean is therefore its sum shifted right by twice the side's exponent, and no divider is needed.

The window origins and side exponents are elaboration-time parameters. At each end-of-frame pixel the block publishes the new means for all regions and raises a one-cycle completion strobe. The default geometry puts four 64x64 corner regions on a 1280x720 raster.

Top module: `vid_region_avg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `avg_rgb` is all zeros and `frame_done` is low. The pixel coordinate restarts at column 0, row 0.
- R2: Each valid pixel advances the column by one. A valid pixel with `eol` high makes the next pixel column 0 of the next row. A valid pixel with `eof` high makes the next pixel column 0, row 0.
- R3: Region i contains a pixel at column x, row y exactly when X0 <= x < X0+2^L and Y0 <= y < Y0+2^L, where X0, Y0 and L are that region's parameter fields.
- R4: Regions accumulate independently. A pixel inside several overlapping regions is added to every one of them.
- R5: A published mean is floor(S / 4^L) for each channel, where S is the channel's sum over the frame. Red is bits [23:16], green is [15:8] and blue is [7:0] of the region's 24-bit slot. Region i occupies `avg_rgb[24*i+23 : 24*i]`.
- R6: The pixel that carries `eof` is included in the frame's sums. The new means appear on `avg_rgb` on the clock edge that accepts that pixel. `frame_done` is high for exactly that one following cycle.
- R7: Sums restart from zero after every end-of-frame pixel, so one frame's means do not depend on earlier frames.
- R8: Between end-of-frame pixels, `avg_rgb` holds its value.
- R9: A cycle with `pix_valid` low has no effect: its `pix_rgb`, `eol` and `eof` values change neither the coordinate nor any sum, and they do not trigger an output update.
- R10: A region filled entirely with full-scale pixels (0xFFFFFF) reports 0xFFFFFF, with no accumulator wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Qualifies the pixel word and markers this cycle |
| pix_rgb | input | 24 | Pixel color, red [23:16], green [15:8], blue [7:0] |
| eol | input | 1 | High on the last pixel of a row |
| eof | input | 1 | High on the last pixel of a frame |
| avg_rgb | output | 24*NUM_REG | Per-region mean color, region i at bits 24*i upward |
| frame_done | output | 1 | One-cycle strobe when new means are published |

## Verification
The test uses four stimulus patterns. A full-scale white frame shows whether the accumulators are wide enough. A coordinate ramp gives every column and row distinct channel values, so a window shifted or widened by one pixel in either axis produces a different mean. A checkerboard mixes values within one region and tests the rounding of the shift. A frame with idle cycles, where each idle cycle carries junk pixels and false markers, separates correct qualification from counters or sums that ignore `pix_valid`. A black frame after the bright ones, followed by long idle stretches, exposes sums that are not cleared and outputs that are not held.

// File: rtl/vra_pkg.sv
package vra_pkg;
   localparam int CH_W   = 8;
   localparam int NUM_CH = 3;
   localparam int PIX_W  = CH_W * NUM_CH;
   localparam int LOG2_W = 4;

   typedef logic [CH_W-1:0] chan_t;

   // channel c of a packed pixel: 0 = blue, 1 = green, 2 = red
   function automatic chan_t pick_chan(input logic [PIX_W-1:0] pix, input int c);
      return pix[c*CH_W +: CH_W];
   endfunction
endpackage

// File: rtl/vra_pos_counter.sv
module vra_pos_counter #(
   parameter int X_W = 11,
   parameter int Y_W = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic           row_end,
   input  logic           frm_end,
   output logic [X_W-1:0] col,
   output logic [Y_W-1:0] row
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (adv) begin
         if (frm_end) begin
            col <= '0;
            row <= '0;
         end else if (row_end) begin
            col <= '0;
            row <= row + 1'b1;
         end else begin
            col <= col + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vra_region_acc.sv
module vra_region_acc
   import vra_pkg::*;
#(
   parameter int X_W  = 11,
   parameter int Y_W  = 10,
   parameter int X0   = 0,
   parameter int Y0   = 0,
   parameter int LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             frm_end,
   input  logic [X_W-1:0]   col,
   input  logic [Y_W-1:0]   row,
   input  logic [PIX_W-1:0] pix,
   output logic [PIX_W-1:0] mean
);
   localparam int SIDE  = 1 << LOG2;
   localparam int SHIFT = 2 * LOG2;
   localparam int ACC_W = CH_W + SHIFT;
   localparam logic [X_W:0] XLO = (X_W+1)'(X0);
   localparam logic [X_W:0] XHI = (X_W+1)'(X0 + SIDE);
   localparam logic [Y_W:0] YLO = (Y_W+1)'(Y0);
   localparam logic [Y_W:0] YHI = (Y_W+1)'(Y0 + SIDE);

   logic hit;
   assign hit = ({1'b0, col} >= XLO) && ({1'b0, col} < XHI) &&
                ({1'b0, row} >= YLO) && ({1'b0, row} < YHI);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [ACC_W-1:0] acc;
      logic [ACC_W-1:0] sum_nx;
      logic [CH_W-1:0]  avg_nx;
      logic [CH_W-1:0]  avg_q;

      assign sum_nx = acc + (hit ? ACC_W'(pick_chan(pix, c)) : '0);

      if (SHIFT == 0) begin : g_noshift
         assign avg_nx = sum_nx;
      end else begin : g_shift
         logic [ACC_W-1:0] shifted;
         assign shifted = sum_nx >> SHIFT;
         assign avg_nx  = shifted[CH_W-1:0];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc   <= '0;
            avg_q <= '0;
         end else if (adv) begin
            if (frm_end) begin
               avg_q <= avg_nx;
               acc   <= '0;
            end else begin
               acc   <= sum_nx;
            end
         end
      end

      assign mean[c*CH_W +: CH_W] = avg_q;
   end
endmodule

// File: rtl/vid_region_avg.sv
module vid_region_avg
   import vra_pkg::*;
#(
   parameter int NUM_REG = 4,
   parameter int X_W     = 11,
   parameter int Y_W     = 10,
   parameter logic [NUM_REG*X_W-1:0]    REG_X0   = {11'd1216, 11'd0, 11'd1216, 11'd0},
   parameter logic [NUM_REG*Y_W-1:0]    REG_Y0   = {10'd656, 10'd656, 10'd0, 10'd0},
   parameter logic [NUM_REG*LOG2_W-1:0] REG_LOG2 = {4'd6, 4'd6, 4'd6, 4'd6}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pix_valid,
   input  logic [PIX_W-1:0]         pix_rgb,
   input  logic                     eol,
   input  logic                     eof,
   output logic [NUM_REG*PIX_W-1:0] avg_rgb,
   output logic                     frame_done
);
   localparam int MAX_LOG2 = 11;

   if (NUM_REG < 1) begin : g_bad_num
      $error("vid_region_avg: NUM_REG must be at least 1");
   end
   if (X_W < 1 || Y_W < 1) begin : g_bad_w
      $error("vid_region_avg: coordinate widths must be positive");
   end

   logic [X_W-1:0] pos_x;
   logic [Y_W-1:0] pos_y;

   vra_pos_counter #(.X_W(X_W), .Y_W(Y_W)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (pix_valid),
      .row_end (eol),
      .frm_end (eof),
      .col     (pos_x),
      .row     (pos_y)
   );

   for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
      localparam int RX0 = int'(REG_X0[i*X_W +: X_W]);
      localparam int RY0 = int'(REG_Y0[i*Y_W +: Y_W]);
      localparam int RL  = int'(REG_LOG2[i*LOG2_W +: LOG2_W]);

      if (RL > MAX_LOG2) begin : g_bad_l
         $error("vid_region_avg: region side exponent too large");
      end
      if (RX0 + (1 << RL) > (1 << X_W) || RY0 + (1 << RL) > (1 << Y_W)) begin : g_bad_fit
         $error("vid_region_avg: region window exceeds coordinate range");
      end

      vra_region_acc #(
         .X_W (X_W), .Y_W (Y_W), .X0 (RX0), .Y0 (RY0), .LOG2 (RL)
      ) u_acc (
         .clk     (clk),
         .rst_n   (rst_n),
         .adv     (pix_valid),
         .frm_end (eof),
         .col     (pos_x),
         .row     (pos_y),
         .pix     (pix_rgb),
         .mean    (avg_rgb[i*PIX_W +: PIX_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) frame_done <= 1'b0;
      else        frame_done <= pix_valid && eof;
   end
endmodule

// File: rtl/vid_region_avg_chk.sv
module vid_region_avg_chk #(
   parameter int NUM_REG = 4,
   parameter int X_W     = 11,
   parameter int Y_W     = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  pix_valid,
   input logic                  eol,
   input logic                  eof,
   input logic [NUM_REG*24-1:0] avg_rgb,
   input logic                  frame_done,
   input logic [X_W-1:0]        cur_x,
   input logic [Y_W-1:0]        cur_y
);
   // R6
   done_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && eof) |=> frame_done);

   // R6
   done_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(pix_valid && eof));

   // R8
   avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |-> $stable(avg_rgb));

   // R2
   col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && (eol || eof)) |=> (cur_x == '0));

   // R2
   col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !eol && !eof) |=> (cur_x == X_W'($past(cur_x) + 1'b1)));

   // R2
   row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && eof) |=> (cur_y == '0));

   // R9
   idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ($stable(cur_x) && $stable(cur_y)));
endmodule

bind vid_region_avg vid_region_avg_chk #(
   .NUM_REG (NUM_REG), .X_W (X_W), .Y_W (Y_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_valid  (pix_valid),
   .eol        (eol),
   .eof        (eof),
   .avg_rgb    (avg_rgb),
   .frame_done (frame_done),
   .cur_x      (pos_x),
   .cur_y      (pos_y)
);

// File: tb/vid_region_avg_bench.sv
module vid_region_avg_bench;
   localparam int NR = 4;
   localparam int XW = 6;
   localparam int YW = 5;
   localparam int FW = 20;
   localparam int FH = 16;
   // region origins and side exponents used by the model
   localparam int MX0 [NR] = '{0, 4, 2, 12};
   localparam int MY0 [NR] = '{0, 0, 2, 8};
   localparam int ML  [NR] = '{2, 1, 2, 3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_valid = 1'b0;
   logic [23:0] pix_rgb = '0;
   logic eol = 1'b0;
   logic eof = 1'b0;
   logic [NR*24-1:0] avg_rgb;
   logic frame_done;

   always #2 clk = ~clk;

   vid_region_avg #(
      .NUM_REG (NR), .X_W (XW), .Y_W (YW),
      .REG_X0   ({6'd12, 6'd2, 6'd4, 6'd0}),
      .REG_Y0   ({5'd8, 5'd2, 5'd0, 5'd0}),
      .REG_LOG2 ({4'd3, 4'd2, 4'd1, 4'd2})
   ) u_vid_region_avg (
      .clk (clk), .rst_n (rst_n), .pix_valid (pix_valid), .pix_rgb (pix_rgb),
      .eol (eol), .eof (eof), .avg_rgb (avg_rgb), .frame_done (frame_done)
   );

   int checks = 0;
   int errors = 0;
   string phase = "R1 reset";

   // reference model
   int m_x, m_y;
   int m_sum [NR][3];
   logic [23:0] m_avg [NR];
   logic m_done;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_x = 0; m_y = 0; m_done = 1'b0;
         for (int r = 0; r < NR; r++) begin
            m_avg[r] = '0;
            for (int c = 0; c < 3; c++) m_sum[r][c] = 0;
         end
      end else begin
         m_done = 1'b0;
         if (pix_valid) begin
            for (int r = 0; r < NR; r++) begin
               if (m_x >= MX0[r] && m_x < MX0[r] + (1 << ML[r]) &&
                   m_y >= MY0[r] && m_y < MY0[r] + (1 << ML[r]))
                  for (int c = 0; c < 3; c++)
                     m_sum[r][c] += int'(pix_rgb[c*8 +: 8]);
            end
            if (eof) begin
               for (int r = 0; r < NR; r++) begin
                  for (int c = 0; c < 3; c++) begin
                     m_avg[r][c*8 +: 8] = 8'(m_sum[r][c] / (1 << (2*ML[r])));
                     m_sum[r][c] = 0;
                  end
               end
               m_done = 1'b1;
               m_x = 0; m_y = 0;
            end else if (eol) begin
               m_x = 0; m_y++;
            end else begin
               m_x++;
            end
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      checks++;
      if (frame_done !== m_done) begin
         errors++;
         $display("FAIL %s frame_done got %b exp %b", phase, frame_done, m_done);
      end
      for (int r = 0; r < NR; r++) begin
         checks++;
         if (avg_rgb[r*24 +: 24] !== m_avg[r]) begin
            errors++;
            $display("FAIL %s region %0d avg got %h exp %h", phase, r,
                     avg_rgb[r*24 +: 24], m_avg[r]);
         end
      end
   end

   function automatic logic [23:0] pat(input int mode, input int x, input int y);
      case (mode)
         0: return 24'hFFFFFF;
         1: return {8'(x*12 + 3), 8'(y*15 + 1), 8'(x*5 + y*9)};
         2: return ((x ^ y) & 1) != 0 ? 24'hFF00FF : 24'h10E021;
         default: return 24'h000000;
      endcase
   endfunction

   task automatic drive(input logic v, input logic [23:0] p, input logic h, input logic f);
      @(negedge clk);
      pix_valid = v; pix_rgb = p; eol = h; eof = f;
   endtask

   task automatic frame(input int mode, input bit gaps);
      for (int y = 0; y < FH; y++) begin
         for (int x = 0; x < FW; x++) begin
            if (gaps && ((x + y) % 3 == 0))
               drive(1'b0, 24'hFFFFFF, 1'b1, 1'b1);   // R9 junk while idle
            drive(1'b1, pat(mode, x, y), x == FW-1, (x == FW-1) && (y == FH-1));
         end
      end
      drive(1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 24'h5A5A5A, 1'b0, 1'b0);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog expired, got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      phase = "R1 reset";
      idle(5);
      rst_n = 1'b1;
      idle(2);
      phase = "R10 full-scale frame";
      frame(0, 1'b0);
      idle(3);
      phase = "R3 R4 R5 ramp windows";
      frame(1, 1'b0);
      phase = "R2 R6 checkerboard";
      frame(2, 1'b0);
      phase = "R9 gapped ramp";
      frame(1, 1'b1);
      phase = "R7 black after bright";
      frame(3, 1'b0);
      phase = "R8 idle hold";
      idle(40);
      phase = "R5 back-to-back ramp";
      frame(1, 1'b0);
      frame(2, 1'b0);
      idle(4);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule